// File: doc/BRIEF.md
# Radio Altitude Validation and Selection

This block takes the height words of two radio altimeters and turns them into the single height figure that the control laws consume. Each altimeter word arrives with a one-cycle strobe, a two-bit status field and a parity bit. The block qualifies each source on its own, then combines the qualified sources into one output height.

A source is usable only while all of the following hold:
- its last word had a normal status code and correct parity;
- that word is still recent;
- the source has never reported a near-ground height while the aircraft was flying fast. That last failure locks the source out until reset.

The combiner works from the number of usable sources, the calibrated airspeed and a qualified full flap/slat configuration. When the block cannot trust the height, it substitutes a fixed "high" value of 250 ft and raises a flag.

Time is measured in ticks of an external 1 ms strobe. The refresh window and the disagreement threshold are run-time inputs. The configuration qualification time is a parameter.

Top module: `ra_alt_select`

## Requirements
- R1: After reset, `alt_ft` is 250, `alt_forced` is 1, and `ra_ok` and `ra_locked` are both 0.
- R2: A strobed word is accepted only when its status field equals 2'b11. A strobed word with any other status clears that source's `ra_ok` bit.
- R3: Parity is odd over the concatenation {status, height, parity bit}. A strobed word with even parity is rejected and clears that source's `ra_ok` bit.
- R4: A source's `ra_ok` bit falls on the `refresh_ms`-th tick that arrives after its last accepted word with no new accepted word in between. The next accepted word sets it again.
- R5: An accepted word with height below 50 ft, received while `cas_kt` is above 200, sets that source's `ra_locked` bit. The bit stays set and holds `ra_ok` low through any later good words. Only reset clears it.
- R6: When both sources are usable and the absolute difference of their heights is at most `diff_thresh`, `alt_ft` is the rounded-down half-sum and `alt_forced` is 0.
- R7: When both sources are usable, their difference exceeds `diff_thresh` and the configuration is not qualified, `alt_ft` is 250 and `alt_forced` is 1.
- R8: The configuration is qualified once `full_cfg` has been high for CFG_QUAL_MS ticks. While qualified, a disagreement yields the half-sum with `alt_forced` at 0. Any low cycle on `full_cfg` restarts the count.
- R9: With exactly one usable source, the output is forced to 250 if `cas_kt` exceeds 180. Otherwise the output is that source's height, unforced.
- R10: With no usable source, `alt_ft` is 250 and `alt_forced` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| ra0_stb | input | 1 | Word strobe, altimeter 0 |
| ra0_height | input | HW | Height in ft, altimeter 0 |
| ra0_ssm | input | 2 | Status field, altimeter 0 |
| ra0_par | input | 1 | Parity bit, altimeter 0 |
| ra1_stb | input | 1 | Word strobe, altimeter 1 |
| ra1_height | input | HW | Height in ft, altimeter 1 |
| ra1_ssm | input | 2 | Status field, altimeter 1 |
| ra1_par | input | 1 | Parity bit, altimeter 1 |
| cas_kt | input | SW | Calibrated airspeed in kt |
| full_cfg | input | 1 | Full flap/slat configuration discrete |
| diff_thresh | input | HW | Disagreement threshold in ft |
| refresh_ms | input | AW | Refresh window in ticks |
| alt_ft | output | HW | Selected height in ft |
| alt_forced | output | 1 | High substitute in use |
| ra_ok | output | 2 | Per-source usable flag |
| ra_locked | output | 2 | Per-source permanent lockout |

## Verification
The hardest state to reach from the ports is the configuration hold-off. It needs two usable sources that disagree, a full-configuration discrete held for ten thousand ticks, and no expiry of either source during that span.

To get there, the bench first widens the refresh window beyond the qualification time. It then loads two disagreeing words and pulses the tick every other cycle. It checks one tick before and exactly at the qualifying tick. It then drops the discrete to show that the count restarts.

// File: rtl/ra_alt_pkg.sv
package ra_alt_pkg;
  localparam int FORCED_FT       = 250;
  localparam int LOW_HEIGHT_FT   = 50;
  localparam int LOCK_SPEED_KT   = 200;
  localparam int SINGLE_SPEED_KT = 180;
  localparam logic [1:0] SSM_NORMAL = 2'b11;
endpackage

// File: rtl/ra_chan_check.sv
module ra_chan_check
  import ra_alt_pkg::*;
#(
  parameter int HW = 16,
  parameter int SW = 10,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          stb_i,
  input  logic [HW-1:0] height_i,
  input  logic [1:0]    ssm_i,
  input  logic          par_i,
  input  logic [SW-1:0] cas_i,
  input  logic [AW-1:0] limit_i,
  output logic          ok_o,
  output logic          locked_o,
  output logic [HW-1:0] height_o
);
  logic          fresh_q, locked_q;
  logic [AW-1:0] age_q;
  logic [HW-1:0] hgt_q;
  logic          par_ok, ssm_ok, good, low_fast;

  assign par_ok   = ^{ssm_i, height_i, par_i};
  assign ssm_ok   = (ssm_i == SSM_NORMAL);
  assign good     = stb_i && par_ok && ssm_ok;
  assign low_fast = (height_i < HW'(LOW_HEIGHT_FT)) && (cas_i > SW'(LOCK_SPEED_KT));

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q  <= 1'b0;
      locked_q <= 1'b0;
      age_q    <= '0;
      hgt_q    <= '0;
    end else if (good) begin
      fresh_q <= 1'b1;
      age_q   <= '0;
      hgt_q   <= height_i;
      if (low_fast) locked_q <= 1'b1;
    end else if (stb_i) begin
      fresh_q <= 1'b0;
    end else if (tick_i && fresh_q) begin
      if (age_q >= limit_i - AW'(1)) fresh_q <= 1'b0;
      else                           age_q   <= age_q + AW'(1);
    end
  end

  assign ok_o     = fresh_q && !locked_q;
  assign locked_o = locked_q;
  assign height_o = hgt_q;

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);

  // R3
  bad_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !par_ok) |=> !fresh_q);

  // R2
  bad_status_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !ssm_ok) |=> !ok_o);
endmodule

// File: rtl/ra_cfg_qualify.sv
module ra_cfg_qualify #(
  parameter int CFG_QUAL_MS = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic full_cfg_i,
  output logic qualified_o
);
  localparam int CW = $clog2(CFG_QUAL_MS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !full_cfg_i)                      cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(CFG_QUAL_MS)) cnt_q <= cnt_q + CW'(1);
  end

  assign qualified_o = (cnt_q == CW'(CFG_QUAL_MS));

  // R8
  cfg_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !full_cfg_i |=> (cnt_q == '0));
endmodule

// File: rtl/ra_merge.sv
module ra_merge
  import ra_alt_pkg::*;
#(
  parameter int HW = 16,
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    v_i,
  input  logic [HW-1:0] h0_i,
  input  logic [HW-1:0] h1_i,
  input  logic [SW-1:0] cas_i,
  input  logic [HW-1:0] thresh_i,
  input  logic          qual_i,
  output logic [HW-1:0] alt_o,
  output logic          forced_o
);
  logic [HW-1:0] diff, half, alt_d;
  logic [HW:0]   sum;
  logic          forced_d;

  assign diff = (h0_i >= h1_i) ? (h0_i - h1_i) : (h1_i - h0_i);
  assign sum  = {1'b0, h0_i} + {1'b0, h1_i};
  assign half = sum[HW:1];

  always_comb begin
    alt_d    = HW'(FORCED_FT);
    forced_d = 1'b1;
    case (v_i)
      2'b11: begin
        if (diff <= thresh_i || qual_i) begin
          alt_d    = half;
          forced_d = 1'b0;
        end
      end
      2'b01, 2'b10: begin
        if (cas_i <= SW'(SINGLE_SPEED_KT)) begin
          alt_d    = v_i[0] ? h0_i : h1_i;
          forced_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_o    <= HW'(FORCED_FT);
      forced_o <= 1'b1;
    end else begin
      alt_o    <= alt_d;
      forced_o <= forced_d;
    end
  end

  // R10
  none_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (v_i == 2'b00) |=> (forced_o && alt_o == HW'(FORCED_FT)));

  // R9
  single_slow_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(v_i) == 1 && cas_i <= SW'(SINGLE_SPEED_KT)) |=> !forced_o);

  // R9
  single_fast_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(v_i) == 1 && cas_i > SW'(SINGLE_SPEED_KT)) |=> forced_o);
endmodule

// File: rtl/ra_alt_select.sv
module ra_alt_select #(
  parameter int HW          = 16,
  parameter int SW          = 10,
  parameter int AW          = 16,
  parameter int CFG_QUAL_MS = 10000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          ra0_stb,
  input  logic [HW-1:0] ra0_height,
  input  logic [1:0]    ra0_ssm,
  input  logic          ra0_par,
  input  logic          ra1_stb,
  input  logic [HW-1:0] ra1_height,
  input  logic [1:0]    ra1_ssm,
  input  logic          ra1_par,
  input  logic [SW-1:0] cas_kt,
  input  logic          full_cfg,
  input  logic [HW-1:0] diff_thresh,
  input  logic [AW-1:0] refresh_ms,
  output logic [HW-1:0] alt_ft,
  output logic          alt_forced,
  output logic [1:0]    ra_ok,
  output logic [1:0]    ra_locked
);
  localparam int NSRC = 2;

  logic          stb_a [NSRC];
  logic [HW-1:0] hin_a [NSRC];
  logic [1:0]    ssm_a [NSRC];
  logic          par_a [NSRC];
  logic [HW-1:0] hq_a  [NSRC];
  logic          qual;

  assign stb_a[0] = ra0_stb;    assign stb_a[1] = ra1_stb;
  assign hin_a[0] = ra0_height; assign hin_a[1] = ra1_height;
  assign ssm_a[0] = ra0_ssm;    assign ssm_a[1] = ra1_ssm;
  assign par_a[0] = ra0_par;    assign par_a[1] = ra1_par;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ra_chan_check #(.HW(HW), .SW(SW), .AW(AW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_ms),
      .stb_i    (stb_a[g]),
      .height_i (hin_a[g]),
      .ssm_i    (ssm_a[g]),
      .par_i    (par_a[g]),
      .cas_i    (cas_kt),
      .limit_i  (refresh_ms),
      .ok_o     (ra_ok[g]),
      .locked_o (ra_locked[g]),
      .height_o (hq_a[g])
    );
  end

  ra_cfg_qualify #(.CFG_QUAL_MS(CFG_QUAL_MS)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_ms),
    .full_cfg_i  (full_cfg),
    .qualified_o (qual)
  );

  ra_merge #(.HW(HW), .SW(SW)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .v_i      (ra_ok),
    .h0_i     (hq_a[0]),
    .h1_i     (hq_a[1]),
    .cas_i    (cas_kt),
    .thresh_i (diff_thresh),
    .qual_i   (qual),
    .alt_o    (alt_ft),
    .forced_o (alt_forced)
  );

  // R7
  disagree_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_ok == 2'b11 && !qual &&
     ((hq_a[0] > hq_a[1]) ? (hq_a[0] - hq_a[1]) : (hq_a[1] - hq_a[0])) > diff_thresh)
    |=> alt_forced);
endmodule

// File: tb/ra_alt_select_tb.sv
`timescale 1ns/1ps
module ra_alt_select_tb;
  localparam int HW = 16, SW = 10, AW = 16, QUAL = 10000;

  logic clk = 1'b0;
  logic rst;
  logic tick_ms = 1'b0;
  logic ra0_stb = 1'b0, ra1_stb = 1'b0;
  logic [HW-1:0] ra0_height = '0, ra1_height = '0;
  logic [1:0] ra0_ssm = 2'b11, ra1_ssm = 2'b11;
  logic ra0_par = 1'b0, ra1_par = 1'b0;
  logic [SW-1:0] cas_kt = 10'd100;
  logic full_cfg = 1'b0;
  logic [HW-1:0] diff_thresh = 16'd20;
  logic [AW-1:0] refresh_ms = 16'd20000;
  logic [HW-1:0] alt_ft;
  logic alt_forced;
  logic [1:0] ra_ok, ra_locked;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ra_alt_select #(.HW(HW), .SW(SW), .AW(AW), .CFG_QUAL_MS(QUAL)) u_dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms),
    .ra0_stb(ra0_stb), .ra0_height(ra0_height), .ra0_ssm(ra0_ssm), .ra0_par(ra0_par),
    .ra1_stb(ra1_stb), .ra1_height(ra1_height), .ra1_ssm(ra1_ssm), .ra1_par(ra1_par),
    .cas_kt(cas_kt), .full_cfg(full_cfg), .diff_thresh(diff_thresh),
    .refresh_ms(refresh_ms), .alt_ft(alt_ft), .alt_forced(alt_forced),
    .ra_ok(ra_ok), .ra_locked(ra_locked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input int ch, input int h, input logic [1:0] ssm, input bit badpar);
    logic p;
    p = ~(^{ssm, HW'(h)}) ^ badpar;
    @(negedge clk);
    if (ch == 0) begin
      ra0_stb = 1'b1; ra0_height = HW'(h); ra0_ssm = ssm; ra0_par = p;
    end else begin
      ra1_stb = 1'b1; ra1_height = HW'(h); ra1_ssm = ssm; ra1_par = p;
    end
    @(negedge clk);
    ra0_stb = 1'b0; ra1_stb = 1'b0;
    settle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_ms = 1'b1;
      @(negedge clk); tick_ms = 1'b0;
    end
    settle();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    chk("R1 alt", alt_ft, 250);
    chk("R1 forced", alt_forced, 1);
    chk("R1 ok", ra_ok, 0);
    chk("R1 locked", ra_locked, 0);
  endtask

  task automatic t_agree();
    cas_kt = 10'd100;
    send(0, 1000, 2'b11, 0);
    send(1, 1010, 2'b11, 0);
    chk("R6 ok", ra_ok, 3);
    chk("R6 alt", alt_ft, 1005);
    chk("R6 forced", alt_forced, 0);
    send(1, 1011, 2'b11, 0);
    chk("R6 odd sum alt", alt_ft, 1005);
    send(1, 1020, 2'b11, 0);
    chk("R6 at threshold alt", alt_ft, 1010);
  endtask

  task automatic t_disagree();
    send(1, 1100, 2'b11, 0);
    chk("R7 alt", alt_ft, 250);
    chk("R7 forced", alt_forced, 1);
  endtask

  task automatic t_cfg();
    full_cfg = 1'b1;
    ticks(QUAL - 1);
    chk("R8 before qual forced", alt_forced, 1);
    ticks(1);
    chk("R8 qualified alt", alt_ft, 1050);
    chk("R8 qualified forced", alt_forced, 0);
    full_cfg = 1'b0;
    settle();
    chk("R8 drop forced", alt_forced, 1);
    full_cfg = 1'b1;
    ticks(5);
    chk("R8 restart forced", alt_forced, 1);
    full_cfg = 1'b0;
    settle();
  endtask

  task automatic t_status_single();
    send(0, 1000, 2'b11, 0);
    send(1, 1000, 2'b01, 0);
    chk("R2 ok", ra_ok, 1);
    chk("R9 slow alt", alt_ft, 1000);
    chk("R9 slow forced", alt_forced, 0);
    cas_kt = 10'd181;
    settle();
    chk("R9 fast forced", alt_forced, 1);
    cas_kt = 10'd180;
    settle();
    chk("R9 180 kt alt", alt_ft, 1000);
    chk("R9 180 kt forced", alt_forced, 0);
    cas_kt = 10'd100;
  endtask

  task automatic t_parity();
    send(1, 800, 2'b11, 0);
    chk("R3 good word ok", ra_ok, 3);
    send(0, 900, 2'b11, 1);
    chk("R3 bad parity ok", ra_ok, 2);
    chk("R3 single alt", alt_ft, 800);
  endtask

  task automatic t_refresh();
    send(0, 600, 2'b11, 0);
    send(1, 600, 2'b11, 0);
    refresh_ms = 16'd50;
    ticks(49);
    chk("R4 before window ok", ra_ok, 3);
    ticks(1);
    chk("R4 expired ok", ra_ok, 0);
    chk("R10 alt", alt_ft, 250);
    chk("R10 forced", alt_forced, 1);
    send(0, 700, 2'b11, 0);
    chk("R4 restored ok", ra_ok, 1);
    chk("R4 restored alt", alt_ft, 700);
    refresh_ms = 16'd20000;
  endtask

  task automatic t_lock();
    cas_kt = 10'd200;
    send(0, 30, 2'b11, 0);
    chk("R5 at 200 kt no lock", ra_locked, 0);
    cas_kt = 10'd250;
    send(0, 30, 2'b11, 0);
    chk("R5 locked", ra_locked, 1);
    chk("R5 ok low", ra_ok[0], 0);
    cas_kt = 10'd100;
    send(0, 500, 2'b11, 0);
    chk("R5 still locked", ra_locked, 1);
    chk("R5 still not ok", ra_ok[0], 0);
    do_reset();
    chk("R5 reset clears", ra_locked, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_agree();
    t_disagree();
    t_cfg();
    t_status_single();
    t_parity();
    t_refresh();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule